// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

A register-mapped general-purpose I/O block made of identical eight-pin ports. Each port has its own register window, and these windows repeat at a fixed byte stride. Each pin has a two-bit drive mode, and that mode sets how the pad is driven.

Pin inputs pass through a two-flop synchroniser. After the synchroniser they can be read back, and they feed a per-pin single-edge detector. A detected edge latches a sticky event bit. Software clears an event bit by writing 1 to it. Each port raises its own interrupt line whenever one of its pins has an event that is also enabled.

A global control word at address 0 serves two purposes. It reports how many ports are built and which core version this is. Its bit 0 switches edge detection and interrupts on or off.

Top module: `gpio_port_array`

## Requirements
- R1: The control word at byte address 0x00 reads back as follows. Bits 15:9 hold the number of ports (parameter NPORTS). Bits 8:2 hold the parameter CORE_VERSION. Bits 1:0 are read/write and reset to 0. Writes have no effect on bits 15:2.
- R2: Port p occupies byte addresses p*0x30 upward, with these offsets:
  - 0x04: synchronised input level
  - 0x08: output data
  - 0x0C: drive mode
  - 0x10: pull-up disable
  - 0x14: event
  - 0x18: interrupt enable
  - 0x1C: force
  - 0x20: edge select

  Any other address, including offset 0x00 of ports above 0, reads 0 and ignores writes.
- R3: Pin n takes its drive mode from bits 2n+1:2n of the drive mode register. The codes are 00 input, 01 push-pull, 10 open-drain and 11 open-source. The pad output value always equals the output data bit. The output enable behaves as follows:
  - input (00): never set
  - push-pull (01): always set
  - open-drain (10): set only when the data bit is 0
  - open-source (11): set only when the data bit is 1
- R4: The pad pull-up enable of a pin is the inverse of its pull-up disable bit, where 1 means disabled.
- R5: The input register returns the pad levels after the two-flop synchroniser. This holds in every drive mode.
- R6: An edge select bit of 1 latches an event on a rising edge of the synchronised input, and 0 latches on a falling edge. An edge in the other direction latches nothing.
- R7: Event bits sit in bits 7:0 and are sticky. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and only a bus write can clear an event.
- R8: Port p's interrupt goes high one cycle after any of its pins holds an event with the matching enable bit set. Other ports' interrupts are unaffected.
- R9: The force register resets to 0 and reads back as written. While a force bit is 1, the matching event bit is set.
- R10: While control bit 0 is 0, no edge latches an event and all port interrupts stay low. Registers remain readable and writable during this time.
- R11: After reset, all of the following hold:
  - all port registers are 0
  - no pad output enable is set
  - all pull-ups are enabled
  - all interrupts are low

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after the address |
| pad_in | input | NPORTS*8 | Pin levels from the pads |
| pad_out | output | NPORTS*8 | Pin output values |
| pad_oe | output | NPORTS*8 | Pin output enables |
| pad_pu_en | output | NPORTS*8 | Pin pull-up enables |
| port_irq | output | NPORTS | One interrupt per port |

## Verification
The assertions assume that reset is applied for at least one clock before any check is made. They also assume that the bus is idle whenever the event-hold property is relied upon. The bench keeps inside both assumptions: it drives the bus only through single-cycle write pulses, and between writes it leaves the write strobe low. Pad inputs change only on falling clock edges and are then held for several cycles. As a result, every edge crosses the synchroniser cleanly before the event register is read.

// File: rtl/gpio_pa_pkg.sv
package gpio_pa_pkg;
  localparam int PINS      = 8;
  localparam int STRIDE    = 'h30;
  localparam int OFF_W     = 6;
  localparam int DATA_W    = 16;

  localparam logic [OFF_W-1:0] OFF_IN   = 6'h04;
  localparam logic [OFF_W-1:0] OFF_DOUT = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MODE = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_PUD  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_EV   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IEN  = 6'h18;
  localparam logic [OFF_W-1:0] OFF_FRC  = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_EDG  = 6'h20;

  typedef enum logic [1:0] {
    DM_INPUT  = 2'b00,
    DM_PUSH   = 2'b01,
    DM_SINK   = 2'b10,
    DM_SOURCE = 2'b11
  } drive_mode_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_pu,
  output logic              irq,
  output logic [PINS-1:0]   ev_o,
  output logic [PINS-1:0]   ien_o
);
  logic [PINS-1:0]   lvl, prev, hit, clr;
  logic [PINS-1:0]   dout_q, pud_q, ev_q, ien_q, frc_q, edg_q;
  logic [2*PINS-1:0] mode_q;

  gpio_sync #(.W(PINS)) u_sync (.clk(clk), .rst(rst), .d(pin_in), .q(lvl));

  always_comb begin
    hit = en ? ((edg_q & lvl & ~prev) | (~edg_q & ~lvl & prev)) : '0;
    clr = (wr && off == OFF_EV) ? wdata[PINS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      dout_q <= '0;
      mode_q <= '0;
      pud_q  <= '0;
      ev_q   <= '0;
      ien_q  <= '0;
      frc_q  <= '0;
      edg_q  <= '0;
      irq    <= 1'b0;
    end else begin
      prev <= lvl;
      ev_q <= (ev_q & ~clr) | hit | frc_q;
      irq  <= en & |(ev_q & ien_q);
      if (wr) begin
        case (off)
          OFF_DOUT: dout_q <= wdata[PINS-1:0];
          OFF_MODE: mode_q <= wdata[2*PINS-1:0];
          OFF_PUD:  pud_q  <= wdata[PINS-1:0];
          OFF_IEN:  ien_q  <= wdata[PINS-1:0];
          OFF_FRC:  frc_q  <= wdata[PINS-1:0];
          OFF_EDG:  edg_q  <= wdata[PINS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_IN:   rdata[PINS-1:0]   = lvl;
      OFF_DOUT: rdata[PINS-1:0]   = dout_q;
      OFF_MODE: rdata[2*PINS-1:0] = mode_q;
      OFF_PUD:  rdata[PINS-1:0]   = pud_q;
      OFF_EV:   rdata[PINS-1:0]   = ev_q;
      OFF_IEN:  rdata[PINS-1:0]   = ien_q;
      OFF_FRC:  rdata[PINS-1:0]   = frc_q;
      OFF_EDG:  rdata[PINS-1:0]   = edg_q;
      default:  rdata = '0;
    endcase
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pad
    drive_mode_t dm;
    assign dm = drive_mode_t'(mode_q[2*i +: 2]);
    always_comb begin
      case (dm)
        DM_PUSH:   pin_oe[i] = 1'b1;
        DM_SINK:   pin_oe[i] = ~dout_q[i];
        DM_SOURCE: pin_oe[i] = dout_q[i];
        default:   pin_oe[i] = 1'b0;
      endcase
    end
  end

  assign pin_out = dout_q;
  assign pin_pu  = ~pud_q;
  assign ev_o    = ev_q;
  assign ien_o   = ien_q;
endmodule

// File: rtl/gpio_port_array.sv
module gpio_port_array
  import gpio_pa_pkg::*;
#(
  parameter int NPORTS       = 7,
  parameter int CORE_VERSION = 3,
  parameter int ADDR_W       = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wen,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NPORTS*PINS-1:0] pad_in,
  output logic [NPORTS*PINS-1:0] pad_out,
  output logic [NPORTS*PINS-1:0] pad_oe,
  output logic [NPORTS*PINS-1:0] pad_pu_en,
  output logic [NPORTS-1:0]      port_irq
);
  localparam int NPINS = NPORTS * PINS;

  logic [1:0]              ctrl_q;
  logic                    ctrl_hit;
  logic [DATA_W-1:0]       port_rd [NPORTS];
  logic [NPORTS-1:0]       port_sel;
  logic [NPINS-1:0]        ev_all, ien_all;
  logic [DATA_W-1:0]       rd_mux;

  assign ctrl_hit = (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_wen && ctrl_hit) ctrl_q <= bus_wdata[1:0];
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(p * STRIDE);
    localparam logic [ADDR_W-1:0] LIM  = ADDR_W'((p + 1) * STRIDE);
    logic [ADDR_W-1:0] rel;
    logic [DATA_W-1:0] rd;

    assign port_sel[p] = (bus_addr >= BASE) && (bus_addr < LIM);
    assign rel         = bus_addr - BASE;
    assign port_rd[p]  = port_sel[p] ? rd : '0;

    gpio_port u_port (
      .clk    (clk),
      .rst    (rst),
      .en     (ctrl_q[0]),
      .wr     (bus_wen && port_sel[p]),
      .off    (rel[OFF_W-1:0]),
      .wdata  (bus_wdata),
      .rdata  (rd),
      .pin_in (pad_in[p*PINS +: PINS]),
      .pin_out(pad_out[p*PINS +: PINS]),
      .pin_oe (pad_oe[p*PINS +: PINS]),
      .pin_pu (pad_pu_en[p*PINS +: PINS]),
      .irq    (port_irq[p]),
      .ev_o   (ev_all[p*PINS +: PINS]),
      .ien_o  (ien_all[p*PINS +: PINS])
    );
  end

  always_comb begin
    rd_mux = ctrl_hit ? {7'(NPORTS), 7'(CORE_VERSION), ctrl_q} : '0;
    for (int p = 0; p < NPORTS; p++) rd_mux = rd_mux | port_rd[p];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_array_chk.sv
module gpio_port_array_chk #(
  parameter int NPORTS = 7,
  parameter int ADDR_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wen,
  input logic [15:0]            bus_wdata,
  input logic [1:0]             ctrl_q,
  input logic [NPORTS*8-1:0]    ev_all,
  input logic [NPORTS*8-1:0]    ien_all,
  input logic [NPORTS*8-1:0]    pad_oe,
  input logic [NPORTS-1:0]      port_irq
);
  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == '0) |=> ctrl_q == $past(bus_wdata[1:0]));

  p_event_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_wen |=> ((ev_all & $past(ev_all)) == $past(ev_all)));

  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |=> port_irq == '0);

  p_reset_state_r11: assert property (@(posedge clk)
    $past(rst) |-> (port_irq == '0 && pad_oe == '0));

  for (genvar p = 0; p < NPORTS; p++) begin : g_irq
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
      port_irq[p] |-> $past(|(ev_all[p*8 +: 8] & ien_all[p*8 +: 8])));
  end
endmodule

bind gpio_port_array gpio_port_array_chk #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .ev_all(ev_all),
  .ien_all(ien_all), .pad_oe(pad_oe), .port_irq(port_irq)
);

// File: tb/sim_gpio_port_array.sv
`timescale 1ns/1ps
module sim_gpio_port_array;
  localparam int NP  = 2;
  localparam int VER = 5;
  localparam int AW  = 12;
  localparam int NPIN = NP * 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   addr = '0;
  logic            wen = 1'b0;
  logic [15:0]     wdata = '0;
  logic [15:0]     rdata;
  logic [NPIN-1:0] pin = '0;
  logic [NPIN-1:0] pout, poe, ppu;
  logic [NP-1:0]   irq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  gpio_port_array #(.NPORTS(NP), .CORE_VERSION(VER), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata),
    .bus_rdata(rdata), .pad_in(pin), .pad_out(pout), .pad_oe(poe),
    .pad_pu_en(ppu), .port_irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = 16'(d); wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int CTRL_RO = (NP << 9) | (VER << 2);

  initial begin
    int v;
    int exp_oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    rd(0, v);
    chk(v == CTRL_RO, "R11 ctrl reset", v, CTRL_RO);
    chk(poe == '0 && irq == '0, "R11 oe/irq reset", int'(poe), 0);
    chk(ppu == '1, "R11 pull-ups enabled", int'(ppu), 'hFFFF);
    rd('h30 + 'h1C, v);
    chk(v == 0, "R9 force resets to zero", v, 0);
    // R1 control word
    wr(0, 'hFFFF);
    rd(0, v);
    chk(v == (CTRL_RO | 3), "R1 ctrl rw bits", v, CTRL_RO | 3);
    wr(0, 2);
    rd(0, v);
    chk(v == (CTRL_RO | 2), "R1 ctrl write 2", v, CTRL_RO | 2);
    // R2 address map
    for (int p = 0; p < NP; p++) begin
      for (int o = 1; o <= 8; o++) begin
        if (o == 1 || o == 5) continue;
        wr(p * 'h30 + o * 4, 'h11 * (p + 1) + o);
      end
    end
    for (int p = 0; p < NP; p++) begin
      for (int o = 1; o <= 8; o++) begin
        if (o == 1 || o == 5) continue;
        rd(p * 'h30 + o * 4, v);
        chk(v == ('h11 * (p + 1) + o), "R2 register readback", v, 'h11 * (p + 1) + o);
      end
    end
    wr('h30, 'hABCD);
    rd('h30, v);
    chk(v == 0, "R2 port1 offset0 reads zero", v, 0);
    wr(NP * 'h30 + 8, 'h77);
    rd(NP * 'h30 + 8, v);
    chk(v == 0, "R2 beyond last port", v, 0);
    // clear all registers
    for (int p = 0; p < NP; p++)
      for (int o = 2; o <= 8; o++) wr(p * 'h30 + o * 4, (o == 5) ? 'hFF : 0);
    // R3 drive-mode sweep
    for (int p = 0; p < NP; p++) begin
      for (int n = 0; n < 8; n++) begin
        for (int m = 0; m < 4; m++) begin
          for (int d = 0; d < 2; d++) begin
            wr(p * 'h30 + 'h0C, m << (2 * n));
            wr(p * 'h30 + 'h08, d << n);
            exp_oe = (m == 1) ? 1 : (m == 2) ? (d == 0 ? 1 : 0) : (m == 3) ? d : 0;
            chk(poe[p*8+n] == exp_oe[0], "R3 pad oe", int'(poe[p*8+n]), exp_oe);
            chk(pout[p*8+n] == d[0], "R3 pad out", int'(pout[p*8+n]), d);
            chk($countones(poe) == exp_oe, "R3 other pins quiet", $countones(poe), exp_oe);
          end
        end
      end
      wr(p * 'h30 + 'h0C, 0);
      wr(p * 'h30 + 'h08, 0);
    end
    // R4 pull-ups
    for (int p = 0; p < NP; p++) begin
      wr(p * 'h30 + 'h10, 'h5A ^ p);
      chk(ppu[p*8 +: 8] == 8'(~('h5A ^ p)), "R4 pull-up enable", int'(ppu[p*8 +: 8]), ~('h5A ^ p) & 'hFF);
      wr(p * 'h30 + 'h10, 0);
    end
    // R5 synchronised input level
    for (int k = 0; k < 4; k++) begin
      pin = NPIN'('h3C96 * (k + 1));
      for (int p = 0; p < NP; p++) begin
        wr(p * 'h30 + 'h0C, 'h5555 * (k % 2));
        idle(3);
        rd(p * 'h30 + 4, v);
        chk(v == int'(pin[p*8 +: 8]), "R5 input level", v, int'(pin[p*8 +: 8]));
        wr(p * 'h30 + 'h0C, 0);
      end
    end
    // R6/R7/R8 edge detection
    wr(0, 1);
    for (int p = 0; p < NP; p++) wr(p * 'h30 + 'h18, 'hFF);
    for (int p = 0; p < NP; p++) begin
      for (int n = 0; n < 8; n++) begin
        for (int e = 0; e < 2; e++) begin
          @(negedge clk); pin = '0; pin[p*8+n] = ~e[0];
          idle(4);
          wr(p * 'h30 + 'h20, e << n);
          for (int q = 0; q < NP; q++) wr(q * 'h30 + 'h14, 'hFF);
          idle(2);
          @(negedge clk); pin[p*8+n] = e[0];
          idle(4);
          rd(p * 'h30 + 'h14, v);
          chk(v == (1 << n), "R6 selected edge latched", v, 1 << n);
          chk(irq == NP'(1 << p), "R8 port irq", int'(irq), 1 << p);
          wr(p * 'h30 + 'h14, 'hFF & ~(1 << n));
          rd(p * 'h30 + 'h14, v);
          chk(v == (1 << n), "R7 write zero keeps event", v, 1 << n);
          wr(p * 'h30 + 'h14, 1 << n);
          rd(p * 'h30 + 'h14, v);
          chk(v == 0, "R7 write one clears", v, 0);
          @(negedge clk); pin[p*8+n] = ~e[0];
          idle(4);
          rd(p * 'h30 + 'h14, v);
          chk(v == 0, "R6 opposite edge ignored", v, 0);
          chk(irq == '0, "R8 irq low after clear", int'(irq), 0);
        end
      end
      wr(p * 'h30 + 'h20, 0);
    end
    // R9 force
    wr('h30 + 'h1C, 'h24);
    rd('h30 + 'h1C, v);
    chk(v == 'h24, "R9 force readback", v, 'h24);
    rd('h30 + 'h14, v);
    chk(v == 'h24, "R9 force sets event", v, 'h24);
    wr('h30 + 'h1C, 0);
    wr('h30 + 'h14, 'hFF);
    rd('h30 + 'h14, v);
    chk(v == 0, "R9 event clears after force off", v, 0);
    // R10 disabled block
    wr(0, 0);
    @(negedge clk); pin = '1;
    idle(4);
    @(negedge clk); pin = '0;
    idle(4);
    rd(0 * 'h30 + 'h14, v);
    chk(v == 0, "R10 no edge while off", v, 0);
    wr(0 * 'h30 + 'h1C, 1);
    idle(3);
    chk(irq == '0, "R10 irq gated while off", int'(irq), 0);
    rd(0 * 'h30 + 'h14, v);
    chk(v == 1, "R10 registers still live", v, 1);
    wr(0, 1);
    idle(3);
    chk(irq == 2'b01, "R10 irq after enable", int'(irq), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule